// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A top-level table of 4096 word-sized descriptors, each spanning 1 MB, sits at a 16 KB aligned base. A descriptor there can end the walk as a 1 MB section, or it can point to a 1 KB aligned second-level table of 256 descriptors, each spanning a 4 KB small page.

The walker takes one request at a time. It issues each descriptor read on a simple request/valid memory port and decodes the returned word. It then reports the physical address with the memory attributes of the mapping (shared, TEX, access bits, execute-never, cacheable/bufferable), or a translation fault tagged with the level that produced it. While a walk is in flight the walker reports itself busy and accepts no new request. The caller keeps any translation cache and checks permissions against the current mode.

Top module: `xw_walker`

## Requirements
- R1: After reset, `busy`, `mem_req` and `rsp_valid` are low.
- R2: A request is taken only while `busy` is low. The first read goes to {`ttb_base`[31:14], VA[31:20], 2'b00}. A `req_valid` raised while busy changes neither the walk in progress nor the reads issued.
- R3: A first-level descriptor with bits [1:0] = 2'b10 is a section. The walk ends after one read with PA = {desc[31:20], VA[19:0]}, `rsp_section` high, shared = bit 16, TEX = bits [14:12], `rsp_ap` = {bit 15, bits [11:10]}, execute-never = bit 4, C/B = bits [3:2].
- R4: A first-level descriptor with bits [1:0] = 2'b01 points to a second-level table. The second read goes to {desc[31:10], VA[19:12], 2'b00}, so descriptor bits [9:2] do not affect it.
- R5: A second-level descriptor with bits [1:1] set (2'b10 or 2'b11) is a small page. PA = {desc[31:12], VA[11:0]}, `rsp_section` is low, shared = bit 10, TEX = bits [8:6], `rsp_ap` = {bit 9, bits [5:4]}, C/B = bits [3:2], and execute-never equals bit 0 (2'b11 never-execute, 2'b10 executable).
- R6: A first-level descriptor of type 2'b00 or 2'b11 ends the walk after one read with `rsp_fault` high, `rsp_fault_lvl` = 0, and PA and attributes zero.
- R7: A second-level descriptor of type 2'b00 or 2'b01 ends the walk with `rsp_fault` high, `rsp_fault_lvl` = 1, and PA and attributes zero.
- R8: `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_valid` high, for any memory latency including zero wait cycles.
- R9: `rsp_valid` is high for exactly one cycle per walk, with `busy` still high in that cycle. The response fields hold their values until the next response.
- R10: A `mem_valid` pulse while no read is outstanding has no effect: `busy`, `mem_req` and `rsp_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ttb_base | input | 32 | Base of the top-level table, 16 KB aligned |
| req_valid | input | 1 | Start a walk for `req_va` (taken when not busy) |
| req_va | input | 32 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Descriptor read outstanding |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_valid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_lvl | output | 1 | Fault level: 0 top, 1 second |
| rsp_pa | output | 32 | Physical address |
| rsp_section | output | 1 | Result came from a section mapping |
| rsp_shared | output | 1 | Shared attribute |
| rsp_tex | output | 3 | TEX attribute |
| rsp_ap | output | 3 | {AP extension, AP[1:0]} |
| rsp_xn | output | 1 | Execute-never |
| rsp_cb | output | 2 | Cacheable/bufferable bits |

## Verification
A corrupted walk state shows at the memory port first. A wrong read address, a missing or extra second read, or a dropped request appears in the cycle the read is issued, before any result comes out. Decode errors show in the single response cycle as a wrong PA, a wrong attribute field or a wrong fault level. A stuck state shows as `busy` never falling or `rsp_valid` lasting longer than one cycle. Each walk therefore compares the exact sequence of read addresses as well as every response field, and the read latency is varied so that handshake slips cannot hide.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int AW         = 32;
    localparam int TOP_IDX_W  = 12;
    localparam int SUB_IDX_W  = 8;
    localparam int WORD_LG2   = 2;
    localparam int SECT_OFF_W = AW - TOP_IDX_W;
    localparam int PAGE_OFF_W = SECT_OFF_W - SUB_IDX_W;
    localparam int TOP_ALIGN  = TOP_IDX_W + WORD_LG2;
    localparam int SUB_ALIGN  = SUB_IDX_W + WORD_LG2;

    typedef enum logic [1:0] {
        TOP_NONE  = 2'b00,
        TOP_TABLE = 2'b01,
        TOP_SECT  = 2'b10,
        TOP_RSVD  = 2'b11
    } top_kind_e;

    typedef enum logic [1:0] {
        SUB_NONE   = 2'b00,
        SUB_LARGE  = 2'b01,
        SUB_PAGE_X = 2'b10,
        SUB_PAGE_N = 2'b11
    } sub_kind_e;

    typedef struct packed {
        logic       shared;
        logic [2:0] tex;
        logic [2:0] ap;
        logic       xn;
        logic [1:0] cb;
    } attr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ1 = 2'd1,
        ST_READ2 = 2'd2,
        ST_RESP  = 2'd3
    } walk_st_e;
endpackage

// File: rtl/xw_top_dec.sv
module xw_top_dec
    import xw_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int OFF_W  = SECT_OFF_W,
    parameter int ALIGN  = SUB_ALIGN
) (
    input  logic [ADDR_W-1:0] desc,
    output top_kind_e         kind,
    output attr_t             attr,
    output logic [ADDR_W-1:0] sect_base,
    output logic [ADDR_W-1:0] table_base
);
    always_comb begin
        kind        = top_kind_e'(desc[1:0]);
        attr.shared = desc[16];
        attr.tex    = desc[14:12];
        attr.ap     = {desc[15], desc[11:10]};
        attr.xn     = desc[4];
        attr.cb     = desc[3:2];
        sect_base   = {desc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        table_base  = {desc[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
    end
endmodule

// File: rtl/xw_sub_dec.sv
module xw_sub_dec
    import xw_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int OFF_W  = PAGE_OFF_W
) (
    input  logic [ADDR_W-1:0] desc,
    output sub_kind_e         kind,
    output logic              is_page,
    output attr_t             attr,
    output logic [ADDR_W-1:0] page_base
);
    always_comb begin
        kind        = sub_kind_e'(desc[1:0]);
        is_page     = desc[1];
        attr.shared = desc[10];
        attr.tex    = desc[8:6];
        attr.ap     = {desc[9], desc[5:4]};
        attr.xn     = desc[0];
        attr.cb     = desc[3:2];
        page_base   = {desc[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int T_IDX  = TOP_IDX_W,
    parameter int S_IDX  = SUB_IDX_W,
    parameter int W_LG2  = WORD_LG2
) (
    input  logic [ADDR_W-1:0] ttb,
    input  logic [ADDR_W-1:0] new_va,
    input  logic [ADDR_W-1:0] walk_va,
    input  logic [ADDR_W-1:0] table_base,
    input  logic [ADDR_W-1:0] sect_base,
    input  logic [ADDR_W-1:0] page_base,
    output logic [ADDR_W-1:0] top_addr,
    output logic [ADDR_W-1:0] sub_addr,
    output logic [ADDR_W-1:0] sect_pa,
    output logic [ADDR_W-1:0] page_pa
);
    localparam int S_OFF  = ADDR_W - T_IDX;
    localparam int P_OFF  = S_OFF - S_IDX;
    localparam int T_ALGN = T_IDX + W_LG2;
    localparam int S_ALGN = S_IDX + W_LG2;

    always_comb begin
        top_addr = {ttb[ADDR_W-1:T_ALGN], new_va[ADDR_W-1:S_OFF], {W_LG2{1'b0}}};
        sub_addr = {table_base[ADDR_W-1:S_ALGN], walk_va[S_OFF-1:P_OFF], {W_LG2{1'b0}}};
        sect_pa  = {sect_base[ADDR_W-1:S_OFF], walk_va[S_OFF-1:0]};
        page_pa  = {page_base[ADDR_W-1:P_OFF], walk_va[P_OFF-1:0]};
    end
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
#(
    parameter int ADDR_W = AW,
    parameter int T_IDX  = TOP_IDX_W,
    parameter int S_IDX  = SUB_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ttb_base,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_fault_lvl,
    output logic [ADDR_W-1:0] rsp_pa,
    output logic              rsp_section,
    output logic              rsp_shared,
    output logic [2:0]        rsp_tex,
    output logic [2:0]        rsp_ap,
    output logic              rsp_xn,
    output logic [1:0]        rsp_cb
);
    localparam int S_OFF = ADDR_W - T_IDX;
    localparam int P_OFF = S_OFF - S_IDX;
    localparam int S_ALG = S_IDX + WORD_LG2;

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] va;
        logic [ADDR_W-1:0] addr;
        logic              fault;
        logic              lvl;
        logic              section;
        logic [ADDR_W-1:0] pa;
        attr_t             attr;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    top_kind_e         top_kind;
    attr_t             top_attr;
    logic [ADDR_W-1:0] sect_base, table_base;
    sub_kind_e         sub_kind;
    logic              sub_is_page;
    attr_t             sub_attr;
    logic [ADDR_W-1:0] page_base;
    logic [ADDR_W-1:0] top_addr, sub_addr, sect_pa, page_pa;

    xw_top_dec #(.ADDR_W(ADDR_W), .OFF_W(S_OFF), .ALIGN(S_ALG)) u_top_dec (
        .desc       (mem_rdata),
        .kind       (top_kind),
        .attr       (top_attr),
        .sect_base  (sect_base),
        .table_base (table_base)
    );

    xw_sub_dec #(.ADDR_W(ADDR_W), .OFF_W(P_OFF)) u_sub_dec (
        .desc      (mem_rdata),
        .kind      (sub_kind),
        .is_page   (sub_is_page),
        .attr      (sub_attr),
        .page_base (page_base)
    );

    xw_addr_gen #(.ADDR_W(ADDR_W), .T_IDX(T_IDX), .S_IDX(S_IDX), .W_LG2(WORD_LG2)) u_addr (
        .ttb        (ttb_base),
        .new_va     (req_va),
        .walk_va    (ctx_q.va),
        .table_base (table_base),
        .sect_base  (sect_base),
        .page_base  (page_base),
        .top_addr   (top_addr),
        .sub_addr   (sub_addr),
        .sect_pa    (sect_pa),
        .page_pa    (page_pa)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.st   = ST_READ1;
                    ctx_d.va   = req_va;
                    ctx_d.addr = top_addr;
                end
            end
            ST_READ1: begin
                if (mem_valid) begin
                    ctx_d.st = ST_RESP;
                    if (top_kind == TOP_SECT) begin
                        ctx_d.fault   = 1'b0;
                        ctx_d.lvl     = 1'b0;
                        ctx_d.section = 1'b1;
                        ctx_d.pa      = sect_pa;
                        ctx_d.attr    = top_attr;
                    end else if (top_kind == TOP_TABLE) begin
                        ctx_d.st   = ST_READ2;
                        ctx_d.addr = sub_addr;
                    end else begin
                        ctx_d.fault   = 1'b1;
                        ctx_d.lvl     = 1'b0;
                        ctx_d.section = 1'b0;
                        ctx_d.pa      = '0;
                        ctx_d.attr    = '0;
                    end
                end
            end
            ST_READ2: begin
                if (mem_valid) begin
                    ctx_d.st      = ST_RESP;
                    ctx_d.section = 1'b0;
                    ctx_d.lvl     = 1'b1;
                    if (sub_is_page) begin
                        ctx_d.fault = 1'b0;
                        ctx_d.pa    = page_pa;
                        ctx_d.attr  = sub_attr;
                    end else begin
                        ctx_d.fault = 1'b1;
                        ctx_d.pa    = '0;
                        ctx_d.attr  = '0;
                    end
                end
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        busy          = (ctx_q.st != ST_IDLE);
        mem_req       = (ctx_q.st == ST_READ1) || (ctx_q.st == ST_READ2);
        mem_addr      = ctx_q.addr;
        rsp_valid     = (ctx_q.st == ST_RESP);
        rsp_fault     = ctx_q.fault;
        rsp_fault_lvl = ctx_q.fault & ctx_q.lvl;
        rsp_pa        = ctx_q.pa;
        rsp_section   = ctx_q.section;
        rsp_shared    = ctx_q.attr.shared;
        rsp_tex       = ctx_q.attr.tex;
        rsp_ap        = ctx_q.attr.ap;
        rsp_xn        = ctx_q.attr.xn;
        rsp_cb        = ctx_q.attr.cb;
    end

    logic unused_kind;
    assign unused_kind = ^sub_kind;
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic              rsp_section,
    input logic [ADDR_W-1:0] rsp_pa
);
    // R8
    hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9
    rsp_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (busy && !mem_req));

    // R6
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && !rsp_section));

    // R2
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R10
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !busy);
endmodule

bind xw_walker xw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_valid   (mem_valid),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_section (rsp_section),
    .rsp_pa      (rsp_pa)
);

// File: tb/sim_xw_walker.sv
module sim_xw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ttb_base = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        busy, mem_req, rsp_valid, rsp_fault, rsp_fault_lvl;
    logic [31:0] mem_addr, rsp_pa;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_section, rsp_shared, rsp_xn;
    logic [2:0]  rsp_tex, rsp_ap;
    logic [1:0]  rsp_cb;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xw_walker u0 (
        .clk(clk), .rst_n(rst_n), .ttb_base(ttb_base),
        .req_valid(req_valid), .req_va(req_va), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_fault_lvl(rsp_fault_lvl), .rsp_pa(rsp_pa), .rsp_section(rsp_section),
        .rsp_shared(rsp_shared), .rsp_tex(rsp_tex), .rsp_ap(rsp_ap),
        .rsp_xn(rsp_xn), .rsp_cb(rsp_cb)
    );

    // memory model
    logic [31:0] tab_a [8];
    logic [31:0] tab_d [8];
    int          n_ent = 0;
    int          lat = 0;
    int          wait_cnt = 0;
    logic [31:0] flog [64];
    int          fcount = 0;
    int          stray_req = 0;
    int          stray_done = 0;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        logic [31:0] r = 32'h0;
        for (int i = 0; i < 8; i++)
            if (i < n_ent && tab_a[i] == a) r = tab_d[i];
        return r;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_valid = 1'b0;
            wait_cnt  = 0;
        end else if (mem_valid) begin
            mem_valid = 1'b0;
        end else if (stray_req != stray_done) begin
            stray_done = stray_req;
            mem_valid  = 1'b1;
            mem_rdata  = 32'hFFFF_F002;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = lookup(mem_addr);
                flog[fcount % 64] = mem_addr;
                fcount++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        tab_a[n_ent] = a;
        tab_d[n_ent] = d;
        n_ent++;
    endtask

    // issue one walk, wait for the response pulse; returns first fetch index
    task automatic walk(input logic [31:0] va, output int f0);
        int t;
        f0 = fcount;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk(rsp_valid, "R9 response seen", {31'b0, rsp_valid}, 32'h1);
    endtask

    function automatic logic [31:0] top_of(input logic [31:0] va);
        return {ttb_base[31:14], va[31:20], 2'b00};
    endfunction

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", {31'b0, busy}, 0);
        chk(mem_req == 1'b0, "R1 mem_req", {31'b0, mem_req}, 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'b0, rsp_valid}, 0);
    endtask

    task automatic t_section(input int l);
        logic [31:0] va, d;
        int f0;
        n_ent = 0; lat = l;
        ttb_base = 32'h0008_4000;
        va = 32'h1234_5678;
        // base ABC, shared, tex 101, apx 1 ap 01, xn, cb 10, type 10
        d = 32'hABC0_0000 | (1 << 16) | (5 << 12) | (1 << 15) | (1 << 10) | (1 << 4) | (2 << 2) | 2;
        put(top_of(va), d);
        walk(va, f0);
        chk(fcount - f0 == 1, "R3 one read", fcount - f0, 1);
        chk(flog[f0 % 64] == 32'h0008_448C, "R2 top address", flog[f0 % 64], 32'h0008_448C);
        chk(rsp_pa == 32'hABC4_5678, "R3 section pa", rsp_pa, 32'hABC4_5678);
        chk(!rsp_fault && rsp_section, "R3 section flags", {30'b0, rsp_fault, rsp_section}, 1);
        chk({rsp_shared, rsp_tex, rsp_ap, rsp_xn, rsp_cb} == {1'b1, 3'd5, 3'b101, 1'b1, 2'b10},
            "R3 section attrs", {22'b0, rsp_shared, rsp_tex, rsp_ap, rsp_xn, rsp_cb},
            {22'b0, 1'b1, 3'd5, 3'b101, 1'b1, 2'b10});
        // R9: fields hold after the pulse
        @(negedge clk);
        chk(!rsp_valid && rsp_pa == 32'hABC4_5678, "R9 hold after pulse", rsp_pa, 32'hABC4_5678);
    endtask

    task automatic t_page(input int l, input bit nx);
        logic [31:0] va, d1, d2, exp_pa;
        int f0;
        n_ent = 0; lat = l;
        ttb_base = 32'h0030_0000;
        va = 32'h0040_3ABC;
        d1 = 32'h0012_3400 | 32'h0000_01E4 | 32'h1;  // bits [9:2] junk, type 01
        // base 87654, shared, tex 011, apx 0 ap 11, cb 01
        d2 = 32'h8765_4000 | (1 << 10) | (3 << 6) | (3 << 4) | (1 << 2) | {30'b0, 1'b1, nx};
        put(top_of(va), d1);
        put(32'h0012_340C, d2);
        walk(va, f0);
        exp_pa = 32'h8765_4ABC;
        chk(fcount - f0 == 2, "R4 two reads", fcount - f0, 2);
        chk(flog[f0 % 64] == top_of(va), "R2 top address", flog[f0 % 64], top_of(va));
        chk(flog[(f0 + 1) % 64] == 32'h0012_340C, "R4 second address", flog[(f0 + 1) % 64], 32'h0012_340C);
        chk(rsp_pa == exp_pa && !rsp_fault && !rsp_section, "R5 page pa", rsp_pa, exp_pa);
        chk({rsp_shared, rsp_tex, rsp_ap, rsp_xn, rsp_cb} == {1'b1, 3'd3, 3'b011, nx, 2'b01},
            "R5 page attrs", {22'b0, rsp_shared, rsp_tex, rsp_ap, rsp_xn, rsp_cb},
            {22'b0, 1'b1, 3'd3, 3'b011, nx, 2'b01});
    endtask

    task automatic t_top_fault(input logic [1:0] ty, input int l);
        logic [31:0] va;
        int f0;
        n_ent = 0; lat = l;
        ttb_base = 32'h0100_0000;
        va = 32'hFFF0_1234;
        put(top_of(va), 32'hDEAD_BEEC | {30'b0, ty});
        walk(va, f0);
        chk(fcount - f0 == 1, "R6 one read", fcount - f0, 1);
        chk(rsp_fault && !rsp_fault_lvl, "R6 fault level 0", {30'b0, rsp_fault, rsp_fault_lvl}, 32'h2);
        chk(rsp_pa == 0 && {rsp_shared, rsp_tex, rsp_ap, rsp_xn, rsp_cb} == 0, "R6 zero result", rsp_pa, 0);
    endtask

    task automatic t_sub_fault(input logic [1:0] ty, input int l);
        logic [31:0] va;
        int f0;
        n_ent = 0; lat = l;
        ttb_base = 32'h0000_C000;
        va = 32'h0001_F000;
        put(top_of(va), 32'h0000_0801);
        put(32'h0000_087C, 32'hFFFF_FFFC | {30'b0, ty});
        walk(va, f0);
        chk(fcount - f0 == 2, "R7 two reads", fcount - f0, 2);
        chk(rsp_fault && rsp_fault_lvl, "R7 fault level 1", {30'b0, rsp_fault, rsp_fault_lvl}, 32'h3);
        chk(rsp_pa == 0 && !rsp_section, "R7 zero pa", rsp_pa, 0);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] va;
        int f0, t;
        n_ent = 0; lat = 3;
        ttb_base = 32'h0000_4000;
        va = 32'h0050_0010;
        put(top_of(va), 32'h7770_0002);
        put(top_of(32'h0060_0000), 32'h1110_0002);
        f0 = fcount;
        @(negedge clk);
        req_valid = 1'b1; req_va = va;
        @(negedge clk);
        req_va = 32'h0060_0000;   // held high while busy
        t = 0;
        while (!rsp_valid && t < 100) begin
            @(negedge clk);
            t++;
        end
        req_valid = 1'b0;
        chk(rsp_pa == 32'h7770_0010, "R2 busy request ignored pa", rsp_pa, 32'h7770_0010);
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req, "R2 no walk started while busy", {30'b0, busy, mem_req}, 0);
        chk(fcount - f0 == 1, "R2 no extra read", fcount - f0, 1);
    endtask

    task automatic t_stray();
        int f0;
        f0 = fcount;
        @(posedge clk);
        stray_req++;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !rsp_valid, "R10 stray valid ignored",
            {29'b0, busy, mem_req, rsp_valid}, 0);
        chk(fcount == f0, "R10 no read", fcount - f0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_section(0);
        t_section(2);
        t_page(0, 1'b1);   // R8 zero-wait
        t_page(3, 1'b0);   // R8 with waits
        t_top_fault(2'b00, 1);
        t_top_fault(2'b11, 0);
        t_sub_fault(2'b00, 2);
        t_sub_fault(2'b01, 0);
        t_busy_ignore();
        t_stray();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule